// File: doc/BRIEF.md
# Length-Framed Message Receiver

This block drains one framed message from the inbound side of a ring mailbox. A message is a run of 32-bit words. Its first word is a header, and a length field in that header gives the payload size in bytes. After a start pulse, the receiver first confirms that both ends of the ring report ready and that the filled-slot count makes sense. It then accepts words over a valid/ready stream and writes them into a small local buffer, one word per buffer address.

The number of words that belong to the message is the payload byte count rounded up to whole words, plus one word for the header. If that number is larger than the ring depth, the header is treated as garbage. The receiver then asks for a ring reset, drops everything it had collected and waits for a fresh header. This is how it recovers when framing is lost.

Words that do not fit in the buffer are still taken from the ring but are not stored. A buffer whose size is not a whole number of words keeps only the low bytes of its last word. When the final word has been taken, the receiver checks the peer's ready flag once more. It then either rings the doorbell and reports done, or requests a reset and reports abort. A cycle budget limits the time spent waiting. When the budget runs out, the receiver ends with a timeout.

Top module: `msg_rx_framer`

## Requirements
- R1: After reset, `word_ready_o`, `buf_we_o`, `done_o`, `abort_o`, `timeout_o`, `ring_rst_o` and `doorbell_o` are low and `byte_cnt_o` is 0.
- R2: The payload byte count L is read from header bits [LEN_LSB+LEN_W-1:LEN_LSB], which are bits [24:16] by default. Exactly ceil(L/4)+1 words, counting the header, are accepted before the message completes.
- R3: Accepted word i (the header is i=0) is written at buffer address i with byte enables 4'b1111, for every i below BUF_BYTES/4. The write appears one cycle after the handshake.
- R4: When BUF_BYTES mod 4 = r is not 0, word i = BUF_BYTES/4 is written with only the low r byte-enable bits set and data bits above 8*r forced to zero. All later words are accepted without any write.
- R5: `byte_cnt_o` is cleared when a start is accepted. It then equals min(4 x words accepted, BUF_BYTES) and never exceeds BUF_BYTES.
- R6: A header whose word count exceeds `depth_i` is not stored. It raises `ring_rst_o` for one cycle, leaves `byte_cnt_o` at 0 and sends the receiver back to the readiness check. A following valid header is then received normally.
- R7: Before any word is accepted, if `local_rdy_i` or `peer_rdy_i` is low, or if `fill_i` > `depth_i`, then `ring_rst_o` stays high and `word_ready_o` stays low until the condition clears.
- R8: One cycle after the final word is accepted, the receiver checks `peer_rdy_i`. If it is high, `done_o` and `doorbell_o` pulse together for one cycle. If it is low, `abort_o` and `ring_rst_o` pulse and `doorbell_o` stays low.
- R9: Cycles spent waiting in the readiness check or for a word use up a budget of TIMEOUT cycles. If no word is ever offered, `timeout_o` is high after the (TIMEOUT+3)-th rising edge, counting as the first the edge that samples `start_i`.
- R10: After done, abort or timeout, the receiver is idle. While idle, `word_ready_o` is low, offered words cause no write and `byte_cnt_o` holds its value until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin receiving one message |
| local_rdy_i | input | 1 | This side's ring ready flag |
| peer_rdy_i | input | 1 | Far side's ring ready flag |
| fill_i | input | DEPTH_W | Filled slots reported by the ring |
| depth_i | input | DEPTH_W | Ring depth in words |
| word_valid_i | input | 1 | Inbound word present |
| word_i | input | 32 | Inbound word |
| word_ready_o | output | 1 | Receiver takes the word this cycle |
| buf_we_o | output | 1 | Local buffer write strobe |
| buf_addr_o | output | ADDR_W | Buffer word address |
| buf_be_o | output | 4 | Byte enables, bit k for bits 8k+7:8k |
| buf_data_o | output | 32 | Write data |
| byte_cnt_o | output | BYTE_W | Bytes stored so far |
| done_o | output | 1 | Message complete pulse |
| abort_o | output | 1 | Peer lost ready at completion |
| timeout_o | output | 1 | Budget exhausted pulse |
| ring_rst_o | output | 1 | Ring reset request |
| doorbell_o | output | 1 | Interrupt-generate pulse to the peer |

## Verification
Two things can happen on the same handshake edge: the final word of a message can also be the word that is cut short by truncation, so the masked partial write and the completion decision fall together. The bench sweeps every payload length from 0 to 28 bytes against a 10-byte buffer, so messages end before, on and after the partial word. Each ending is judged on the write strobes, the byte count and a single done pulse. It also drops `peer_rdy_i` in the cycle right after a truncated final word and expects abort with a reset request and no doorbell.

// File: rtl/msgrx_pkg.sv
package msgrx_pkg;

    localparam int unsigned WORD_BYTES = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_RECV,
        ST_FINISH
    } rx_state_e;

    typedef struct packed {
        logic        we;
        logic [3:0]  be;
        logic [31:0] data;
    } store_t;

    // byte-enable mask with the lowest n lanes set (n < 4)
    function automatic logic [3:0] low_lanes(input int unsigned n);
        return 4'((5'd1 << n) - 5'd1);
    endfunction

    // widen a byte-enable into a bit mask over a 32-bit word
    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int k = 0; k < 4; k++) begin
            m[8*k +: 8] = {8{be[k]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/msgrx_hdr.sv
module msgrx_hdr #(
    parameter int unsigned LEN_W   = 9,
    parameter int unsigned DEPTH_W = 8
) (
    input  logic [LEN_W-1:0]   len_i,
    input  logic [DEPTH_W-1:0] depth_i,
    output logic [LEN_W-1:0]   words_o,
    output logic               bad_o
);
    logic [LEN_W:0] rounded;

    assign rounded = {1'b0, len_i} + (LEN_W+1)'(3);
    assign words_o = LEN_W'(rounded[LEN_W:2]) + LEN_W'(1);
    assign bad_o   = 32'(words_o) > 32'(depth_i);
endmodule

// File: rtl/msgrx_pack.sv
module msgrx_pack
    import msgrx_pkg::*;
#(
    parameter int unsigned BUF_BYTES = 10,
    parameter int unsigned IDX_W     = 9
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [31:0]      word_i,
    output store_t           st_o,
    output logic [2:0]       add_o
);
    localparam int unsigned FULL_WORDS = BUF_BYTES / WORD_BYTES;
    localparam int unsigned REM_BYTES  = BUF_BYTES % WORD_BYTES;

    logic full_hit;
    logic part_hit;

    assign full_hit = 32'(idx_i) < FULL_WORDS;

    generate
        if (REM_BYTES == 0) begin : g_whole
            assign part_hit = 1'b0;
        end else begin : g_partial
            assign part_hit = 32'(idx_i) == FULL_WORDS;
        end
    endgenerate

    always_comb begin
        st_o  = '0;
        add_o = '0;
        if (full_hit) begin
            st_o.we   = 1'b1;
            st_o.be   = 4'hF;
            st_o.data = word_i;
            add_o     = 3'd4;
        end else if (part_hit) begin
            st_o.we   = 1'b1;
            st_o.be   = low_lanes(REM_BYTES);
            st_o.data = word_i & lane_mask(low_lanes(REM_BYTES));
            add_o     = 3'(REM_BYTES);
        end
    end
endmodule

// File: rtl/msgrx_timer.sv
module msgrx_timer #(
    parameter int unsigned TIMEOUT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic tick_i,
    output logic expired_o
);
    localparam int unsigned TW = $clog2(TIMEOUT + 1);

    logic [TW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= TW'(TIMEOUT);
        end else if (load_i) begin
            left_q <= TW'(TIMEOUT);
        end else if (tick_i && left_q != '0) begin
            left_q <= left_q - TW'(1);
        end
    end

    assign expired_o = tick_i && (left_q == '0);
endmodule

// File: rtl/msg_rx_framer.sv
module msg_rx_framer
    import msgrx_pkg::*;
#(
    parameter int unsigned LEN_LSB   = 16,
    parameter int unsigned LEN_W     = 9,
    parameter int unsigned DEPTH_W   = 8,
    parameter int unsigned BUF_BYTES = 10,
    parameter int unsigned TIMEOUT   = 1000,
    localparam int unsigned BUF_WORDS = (BUF_BYTES + WORD_BYTES - 1) / WORD_BYTES,
    localparam int unsigned ADDR_W    = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1,
    localparam int unsigned BYTE_W    = $clog2(BUF_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               local_rdy_i,
    input  logic               peer_rdy_i,
    input  logic [DEPTH_W-1:0] fill_i,
    input  logic [DEPTH_W-1:0] depth_i,
    input  logic               word_valid_i,
    input  logic [31:0]        word_i,
    output logic               word_ready_o,
    output logic               buf_we_o,
    output logic [ADDR_W-1:0]  buf_addr_o,
    output logic [3:0]         buf_be_o,
    output logic [31:0]        buf_data_o,
    output logic [BYTE_W-1:0]  byte_cnt_o,
    output logic               done_o,
    output logic               abort_o,
    output logic               timeout_o,
    output logic               ring_rst_o,
    output logic               doorbell_o
);
    localparam int unsigned CNT_W = LEN_W;

    rx_state_e        state_q;
    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] words_q;

    logic [CNT_W-1:0] hdr_words;
    logic             hdr_bad;
    store_t           st;
    logic [2:0]       add_bytes;
    logic             pre_bad;
    logic             hs;
    logic             last_word;
    logic             tmr_load;
    logic             tmr_tick;
    logic             expired;

    msgrx_hdr #(.LEN_W(LEN_W), .DEPTH_W(DEPTH_W)) u_hdr (
        .len_i   (word_i[LEN_LSB +: LEN_W]),
        .depth_i (depth_i),
        .words_o (hdr_words),
        .bad_o   (hdr_bad)
    );

    msgrx_pack #(.BUF_BYTES(BUF_BYTES), .IDX_W(CNT_W)) u_pack (
        .idx_i  (idx_q),
        .word_i (word_i),
        .st_o   (st),
        .add_o  (add_bytes)
    );

    msgrx_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .load_i    (tmr_load),
        .tick_i    (tmr_tick),
        .expired_o (expired)
    );

    assign word_ready_o = (state_q == ST_RECV);
    assign hs           = word_ready_o && word_valid_i;
    assign pre_bad      = !local_rdy_i || !peer_rdy_i || (32'(fill_i) > 32'(depth_i));
    assign last_word    = (idx_q == '0) ? (hdr_words == CNT_W'(1))
                                        : (idx_q + CNT_W'(1) == words_q);
    assign tmr_load     = (state_q == ST_IDLE) && start_i;
    assign tmr_tick     = ((state_q == ST_CHECK) && pre_bad) ||
                          ((state_q == ST_RECV) && !word_valid_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            idx_q      <= '0;
            words_q    <= '0;
            byte_cnt_o <= '0;
            buf_we_o   <= 1'b0;
            buf_addr_o <= '0;
            buf_be_o   <= '0;
            buf_data_o <= '0;
            done_o     <= 1'b0;
            abort_o    <= 1'b0;
            timeout_o  <= 1'b0;
            ring_rst_o <= 1'b0;
            doorbell_o <= 1'b0;
        end else begin
            buf_we_o   <= 1'b0;
            done_o     <= 1'b0;
            abort_o    <= 1'b0;
            timeout_o  <= 1'b0;
            ring_rst_o <= 1'b0;
            doorbell_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q    <= ST_CHECK;
                        idx_q      <= '0;
                        byte_cnt_o <= '0;
                    end
                end
                ST_CHECK: begin
                    if (expired) begin
                        timeout_o <= 1'b1;
                        state_q   <= ST_IDLE;
                    end else if (pre_bad) begin
                        ring_rst_o <= 1'b1;
                    end else begin
                        state_q <= ST_RECV;
                    end
                end
                ST_RECV: begin
                    if (hs) begin
                        if (idx_q == '0 && hdr_bad) begin
                            ring_rst_o <= 1'b1;
                            byte_cnt_o <= '0;
                            state_q    <= ST_CHECK;
                        end else begin
                            if (idx_q == '0) begin
                                words_q <= hdr_words;
                            end
                            if (st.we) begin
                                buf_we_o   <= 1'b1;
                                buf_addr_o <= idx_q[ADDR_W-1:0];
                                buf_be_o   <= st.be;
                                buf_data_o <= st.data;
                                byte_cnt_o <= byte_cnt_o + BYTE_W'(add_bytes);
                            end
                            idx_q <= idx_q + CNT_W'(1);
                            if (last_word) begin
                                state_q <= ST_FINISH;
                            end
                        end
                    end else if (expired) begin
                        timeout_o <= 1'b1;
                        state_q   <= ST_IDLE;
                    end
                end
                ST_FINISH: begin
                    if (peer_rdy_i) begin
                        done_o     <= 1'b1;
                        doorbell_o <= 1'b1;
                    end else begin
                        abort_o    <= 1'b1;
                        ring_rst_o <= 1'b1;
                    end
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/msgrx_chk.sv
module msgrx_chk #(
    parameter int unsigned BUF_BYTES = 10,
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned BYTE_W    = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              word_valid_i,
    input logic              word_ready_o,
    input logic              buf_we_o,
    input logic [ADDR_W-1:0] buf_addr_o,
    input logic [3:0]        buf_be_o,
    input logic [BYTE_W-1:0] byte_cnt_o,
    input logic              done_o,
    input logic              abort_o,
    input logic              timeout_o,
    input logic              ring_rst_o,
    input logic              doorbell_o
);
    localparam logic [3:0] PART_BE = 4'((5'd1 << (BUF_BYTES % 4)) - 5'd1);
    localparam int unsigned BUF_WORDS = (BUF_BYTES + 3) / 4;

    p_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (byte_cnt_o == '0 && !buf_we_o));

    p_write_needs_hs_r3: assert property (@(posedge clk) disable iff (rst)
        buf_we_o |-> $past(word_valid_i && word_ready_o));

    p_be_shape_r4: assert property (@(posedge clk) disable iff (rst)
        buf_we_o |-> ((buf_be_o == 4'hF || buf_be_o == PART_BE) &&
                      32'(buf_addr_o) < BUF_WORDS));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        32'(byte_cnt_o) <= BUF_BYTES);

    p_single_outcome_r8: assert property (@(posedge clk) disable iff (rst)
        $countones({done_o, abort_o, timeout_o}) <= 1);

    p_doorbell_on_done_r8: assert property (@(posedge clk) disable iff (rst)
        doorbell_o |-> (done_o && !ring_rst_o));

    p_idle_after_end_r10: assert property (@(posedge clk) disable iff (rst)
        (done_o || abort_o || timeout_o) |-> !word_ready_o);
endmodule

bind msg_rx_framer msgrx_chk #(
    .BUF_BYTES(BUF_BYTES),
    .ADDR_W   (ADDR_W),
    .BYTE_W   (BYTE_W)
) u_msgrx_chk (
    .clk          (clk),
    .rst          (rst),
    .word_valid_i (word_valid_i),
    .word_ready_o (word_ready_o),
    .buf_we_o     (buf_we_o),
    .buf_addr_o   (buf_addr_o),
    .buf_be_o     (buf_be_o),
    .byte_cnt_o   (byte_cnt_o),
    .done_o       (done_o),
    .abort_o      (abort_o),
    .timeout_o    (timeout_o),
    .ring_rst_o   (ring_rst_o),
    .doorbell_o   (doorbell_o)
);

// File: tb/test_msg_rx_framer.sv
module test_msg_rx_framer;
    localparam int unsigned BUF_BYTES = 10;
    localparam int unsigned TO        = 40;
    localparam int unsigned DEPTH     = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        local_rdy_i = 1'b1;
    logic        peer_rdy_i = 1'b1;
    logic [7:0]  fill_i = 8'd0;
    logic [7:0]  depth_i = 8'(DEPTH);
    logic        word_valid_i = 1'b0;
    logic [31:0] word_i = '0;
    logic        word_ready_o, buf_we_o;
    logic [1:0]  buf_addr_o;
    logic [3:0]  buf_be_o;
    logic [31:0] buf_data_o;
    logic [3:0]  byte_cnt_o;
    logic        done_o, abort_o, timeout_o, ring_rst_o, doorbell_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    int wr_n, done_n, abort_n, bell_n, rrst_n;
    logic [31:0] mem [4];
    logic [3:0]  mbe [4];

    always #10 clk = ~clk;

    msg_rx_framer #(.LEN_LSB(16), .LEN_W(9), .DEPTH_W(8),
                    .BUF_BYTES(BUF_BYTES), .TIMEOUT(TO)) i_msg_rx_framer (
        .clk(clk), .rst(rst), .start_i(start_i), .local_rdy_i(local_rdy_i),
        .peer_rdy_i(peer_rdy_i), .fill_i(fill_i), .depth_i(depth_i),
        .word_valid_i(word_valid_i), .word_i(word_i), .word_ready_o(word_ready_o),
        .buf_we_o(buf_we_o), .buf_addr_o(buf_addr_o), .buf_be_o(buf_be_o),
        .buf_data_o(buf_data_o), .byte_cnt_o(byte_cnt_o), .done_o(done_o),
        .abort_o(abort_o), .timeout_o(timeout_o), .ring_rst_o(ring_rst_o),
        .doorbell_o(doorbell_o));

    always @(negedge clk) begin
        if (buf_we_o) begin
            wr_n++;
            mem[buf_addr_o] = buf_data_o;
            mbe[buf_addr_o] = buf_be_o;
        end
        if (done_o)     done_n++;
        if (abort_o)    abort_n++;
        if (doorbell_o) bell_n++;
        if (ring_rst_o) rrst_n++;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        wr_n = 0; done_n = 0; abort_n = 0; bell_n = 0; rrst_n = 0;
        for (int k = 0; k < 4; k++) begin mem[k] = '0; mbe[k] = '0; end
    endtask

    task automatic kick();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic push(input logic [31:0] w);
        int guard = 0;
        word_valid_i = 1'b1;
        word_i = w;
        while (!word_ready_o && guard < 300) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        word_valid_i = 1'b0;
    endtask

    task automatic wait_end();
        int guard = 0;
        while (done_n + abort_n == 0 && guard < 20) begin
            @(negedge clk);
            guard++;
        end
    endtask

    function automatic logic [31:0] hdr_of(input int len);
        return (32'(len) << 16) | 32'h0000_00A5;
    endfunction

    function automatic logic [31:0] pay_of(input int len, input int i);
        return (32'(len) * 32'h0100_0193) ^ (32'(i) * 32'h1111_1111) ^ 32'h5A00_C3F0;
    endfunction

    // send a full valid message and judge the stored image
    task automatic run_msg(input int len, input bit drop_peer);
        int nw = (len + 3) / 4 + 1;
        int ew = (nw < 3) ? nw : 3;
        int eb = (4 * nw < BUF_BYTES) ? 4 * nw : BUF_BYTES;
        clear_mon();
        kick();
        push(hdr_of(len));
        for (int i = 1; i < nw; i++) push(pay_of(len, i));
        if (drop_peer) peer_rdy_i = 1'b0;
        wait_end();
        @(negedge clk);
        peer_rdy_i = 1'b1;
        if (drop_peer) begin
            chk(abort_n == 1 && done_n == 0, "R8 abort", abort_n, 1);
            chk(bell_n == 0 && rrst_n == 1, "R8 no doorbell, reset", bell_n, 0);
        end else begin
            chk(done_n == 1 && bell_n == 1 && abort_n == 0, "R8 done+doorbell", done_n, 1);
            chk(rrst_n == 0, "R2 no reset on valid frame", rrst_n, 0);
        end
        chk(wr_n == ew, "R2 R4 write count", wr_n, ew);
        chk(32'(byte_cnt_o) == eb, "R5 byte count", byte_cnt_o, eb);
        chk(mem[0] == hdr_of(len) && mbe[0] == 4'hF, "R3 header stored", mem[0], hdr_of(len));
        if (nw >= 2)
            chk(mem[1] == pay_of(len, 1) && mbe[1] == 4'hF, "R3 word1", mem[1], pay_of(len, 1));
        if (nw >= 3)
            chk(mem[2] == (pay_of(len, 2) & 32'h0000_FFFF) && mbe[2] == 4'h3,
                "R4 partial word", mem[2], pay_of(len, 2) & 32'h0000_FFFF);
        chk(!word_ready_o, "R10 idle after end", word_ready_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!word_ready_o && !buf_we_o && !done_o && !abort_o && !timeout_o &&
            !ring_rst_o && !doorbell_o && byte_cnt_o == 0, "R1 reset state",
            {word_ready_o, buf_we_o, byte_cnt_o}, 0);

        // R2 R3 R4 R5 R8: sweep every length that fits the ring
        for (int len = 0; len <= 28; len++) run_msg(len, 1'b0);

        // R8: peer drops ready right after a truncated last word
        run_msg(9, 1'b1);
        run_msg(0, 1'b1);

        // R6: invalid headers (word count 9 > depth 8), then resync
        for (int len = 29; len <= 32; len++) begin
            clear_mon();
            kick();
            push(hdr_of(len));
            chk(ring_rst_o == 1'b1, "R6 reset request on bad header", ring_rst_o, 1);
            chk(wr_n == 0 && byte_cnt_o == 0, "R6 bad header discarded", wr_n, 0);
            push(hdr_of(5));
            push(pay_of(5, 1));
            push(pay_of(5, 2));
            wait_end();
            @(negedge clk);
            chk(done_n == 1 && mem[0] == hdr_of(5), "R6 resync receives", mem[0], hdr_of(5));
            chk(byte_cnt_o == 10, "R6 byte count after resync", byte_cnt_o, 10);
        end

        // R7: pre-check with local not ready, then with fill > depth
        for (int mode = 0; mode < 2; mode++) begin
            clear_mon();
            if (mode == 0) local_rdy_i = 1'b0; else fill_i = 8'd9;
            word_valid_i = 1'b1;
            word_i = hdr_of(4);
            kick();
            repeat (4) @(negedge clk);
            chk(ring_rst_o && !word_ready_o, "R7 reset held before read",
                {ring_rst_o, word_ready_o}, 2'b10);
            chk(wr_n == 0, "R7 no word taken", wr_n, 0);
            word_valid_i = 1'b0;
            local_rdy_i = 1'b1;
            fill_i = 8'd0;
            push(hdr_of(4));
            push(pay_of(4, 1));
            wait_end();
            @(negedge clk);
            chk(done_n == 1 && wr_n == 2 && byte_cnt_o == 8, "R7 proceeds after clear",
                wr_n, 2);
        end

        // R9: timeout with nothing offered
        begin
            int k = 0;
            start_i = 1'b1;
            while (k < 200) begin
                @(negedge clk);
                start_i = 1'b0;
                k++;
                if (timeout_o) break;
            end
            chk(k == TO + 3, "R9 timeout cycle", k, TO + 3);
        end

        // R10: words offered while idle are ignored
        begin
            logic [3:0] keep = byte_cnt_o;
            clear_mon();
            word_valid_i = 1'b1;
            word_i = hdr_of(3);
            repeat (6) @(negedge clk);
            word_valid_i = 1'b0;
            chk(!word_ready_o && wr_n == 0 && byte_cnt_o == keep, "R10 idle ignores words",
                wr_n, 0);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule